// File: doc/BRIEF.md
# Home-Node Coherence Directory Controller

This block sits at the home node of a small shared-memory multiprocessor and tracks, for every memory block homed there, which processors hold a copy. Each tracked block has a record with three parts: a presence vector with one bit per processor, a modified flag, and the ID of the processor that holds the only valid copy while the modified flag is set. Processors send read or write requests tagged with their ID and a block index. The controller updates the record and then does one of three things: it grants the request, it sends invalidations to the other holders and waits for their acknowledgements, or it sends the request on to the processor holding the modified copy.

A small state machine runs each transaction that has to wait. In `ST_IDLE` the controller grants requests that can complete at once. An accepted write that other holders must drop takes the transition *invalidate-start* into `ST_INV_WAIT`. The last expected acknowledgement takes the transition *invalidate-done* back to `ST_IDLE` and grants the write. An accepted read of a block modified by another processor takes the transition *forward-start* into `ST_FWD_WAIT`. The holder's completion acknowledgement takes the transition *forward-done* back to `ST_IDLE` and grants the read.

While a block is waiting, a request for that block is refused in the same cycle with a retry indication. This keeps successive writes to one block in a single order. Requests for other blocks are still granted if they need no waiting.

Top module: `home_directory`

## Requirements
- R1: After reset every record is empty (no holders, not modified), no block is busy, `req_ready` is 1, and `inv_valid`, `fwd_valid` and `rsp_valid` are 0.
- R2: A read of a block that is not modified is granted in the cycle after the handshake (`rsp_valid`=1, `rsp_write`=0). The reader's presence bit is set and the other presence bits are kept.
- R3: A write to an unmodified block that other processors hold sends one `inv_valid` pulse, in the cycle after the handshake. Its mask is the presence vector with the writer's own bit cleared. The block stays busy until every masked processor has acknowledged. The write grant (`rsp_write`=1) comes in the cycle after the last acknowledgement, and the block then reads as modified, owned by the writer, with an empty presence vector.
- R4: A write to an unmodified block that no other processor holds is granted in the cycle after the handshake, with no invalidation.
- R5: A request for the busy block is taken (`req_ready`=1) with `req_nack`=1 in the same cycle. It changes no record and produces no grant.
- R6: A read by a non-owner of a modified block sends one `fwd_valid` pulse, in the cycle after the handshake, carrying the owner, the reader and the block. An acknowledgement from that owner grants the read one cycle later. The block becomes unmodified, with presence bits set for exactly the old owner and the reader.
- R7: A write by a non-owner of a modified block invalidates only the owner. After that acknowledgement, ownership passes to the writer and the block stays modified.
- R8: An acknowledgement from a processor that is not being waited on is ignored. So is a repeated acknowledgement from one that has already answered.
- R9: While one block waits, a request for a different block is granted if it needs no waiting. If it would need waiting, `req_ready` is 0. `req_ready` is also 0 in the cycle in which the wait completes.
- R10: At most one bit of `blk_busy` is set, and it does not change in a cycle without an acknowledgement.
- R11: A read or write by the owner of its own modified block is granted in the cycle after the handshake, with no invalidation and no forward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request taken this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_id | input | 3 | Requesting processor |
| req_blk | input | 4 | Block index |
| req_nack | output | 1 | Taken request refused, retry later |
| ack_valid | input | 1 | Acknowledgement present |
| ack_id | input | 3 | Acknowledging processor |
| inv_valid | output | 1 | Invalidation message |
| inv_mask | output | 8 | Processors to invalidate |
| inv_blk | output | 4 | Block to invalidate |
| fwd_valid | output | 1 | Forward message |
| fwd_owner | output | 3 | Processor holding the modified copy |
| fwd_req | output | 3 | Reader to be supplied |
| fwd_blk | output | 4 | Forwarded block |
| rsp_valid | output | 1 | Grant |
| rsp_write | output | 1 | Grant is for a write |
| rsp_id | output | 3 | Processor granted |
| rsp_blk | output | 4 | Block granted |
| blk_busy | output | 16 | One bit per block waiting for acknowledgements |

## Verification
A wrong record is not visible until the next request for that block. A presence bit that was lost or left set shows up as a wrong `inv_mask`. A stale modified flag or owner shows up as a missing or misdirected forward, or as a grant that came too early. The bench therefore chains requests on one block, so that each record is checked by the transaction after it. A wrong acknowledgement count shows up within one acknowledgement: the grant comes early or late against the scoreboard, and `blk_busy` changes at the wrong edge.

// File: rtl/dirc_pkg.sv
package dirc_pkg;
    typedef enum logic [1:0] {
        ST_IDLE     = 2'd0,
        ST_INV_WAIT = 2'd1,
        ST_FWD_WAIT = 2'd2
    } dir_state_e;
endpackage

// File: rtl/dirc_store.sv
module dirc_store #(
    parameter int unsigned NPROC = 8,
    parameter int unsigned NBLK  = 16,
    localparam int unsigned IDW  = $clog2(NPROC),
    localparam int unsigned BW   = $clog2(NBLK)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [BW-1:0]    rd_blk,
    output logic [NPROC-1:0] rd_pres,
    output logic             rd_dirty,
    output logic [IDW-1:0]   rd_owner,
    input  logic             we,
    input  logic [BW-1:0]    wr_blk,
    input  logic [NPROC-1:0] wr_pres,
    input  logic             wr_dirty,
    input  logic [IDW-1:0]   wr_owner
);
    logic [NPROC-1:0] pres_q  [NBLK];
    logic             dirty_q [NBLK];
    logic [IDW-1:0]   owner_q [NBLK];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NBLK; i++) begin
                pres_q[i]  <= '0;
                dirty_q[i] <= 1'b0;
                owner_q[i] <= '0;
            end
        end else if (we) begin
            pres_q[wr_blk]  <= wr_pres;
            dirty_q[wr_blk] <= wr_dirty;
            owner_q[wr_blk] <= wr_owner;
        end
    end

    assign rd_pres  = pres_q[rd_blk];
    assign rd_dirty = dirty_q[rd_blk];
    assign rd_owner = owner_q[rd_blk];
endmodule

// File: rtl/dirc_acks.sv
module dirc_acks #(
    parameter int unsigned NPROC = 8,
    localparam int unsigned IDW  = $clog2(NPROC),
    localparam int unsigned CW   = $clog2(NPROC + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [NPROC-1:0] load_mask,
    input  logic             ack_valid,
    input  logic [IDW-1:0]   ack_id,
    output logic             last
);
    logic [NPROC-1:0] wait_q;
    logic [CW-1:0]    cnt_q;
    logic             hit;

    function automatic logic [CW-1:0] ones(input logic [NPROC-1:0] v);
        logic [CW-1:0] s;
        s = '0;
        for (int i = 0; i < NPROC; i++) s = s + CW'(v[i]);
        return s;
    endfunction

    assign hit  = ack_valid && wait_q[ack_id];
    assign last = hit && (cnt_q == CW'(1));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wait_q <= '0;
            cnt_q  <= '0;
        end else if (load) begin
            wait_q <= load_mask;
            cnt_q  <= ones(load_mask);
        end else if (hit) begin
            wait_q[ack_id] <= 1'b0;
            cnt_q          <= cnt_q - CW'(1);
        end
    end
endmodule

// File: rtl/home_directory.sv
module home_directory
    import dirc_pkg::*;
#(
    parameter int unsigned NPROC = 8,
    parameter int unsigned NBLK  = 16,
    localparam int unsigned IDW  = $clog2(NPROC),
    localparam int unsigned BW   = $clog2(NBLK)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic             req_write,
    input  logic [IDW-1:0]   req_id,
    input  logic [BW-1:0]    req_blk,
    output logic             req_nack,
    input  logic             ack_valid,
    input  logic [IDW-1:0]   ack_id,
    output logic             inv_valid,
    output logic [NPROC-1:0] inv_mask,
    output logic [BW-1:0]    inv_blk,
    output logic             fwd_valid,
    output logic [IDW-1:0]   fwd_owner,
    output logic [IDW-1:0]   fwd_req,
    output logic [BW-1:0]    fwd_blk,
    output logic             rsp_valid,
    output logic             rsp_write,
    output logic [IDW-1:0]   rsp_id,
    output logic [BW-1:0]    rsp_blk,
    output logic [NBLK-1:0]  blk_busy
);
    dir_state_e state_q, state_d;
    logic [BW-1:0]    pend_blk_q;
    logic [IDW-1:0]   pend_req_q, pend_owner_q;

    logic [NPROC-1:0] rd_pres, wr_pres, req_bit, others, load_mask;
    logic             rd_dirty, wr_dirty, we, inv_last;
    logic [IDW-1:0]   rd_owner, wr_owner;
    logic [BW-1:0]    wr_blk;
    logic             owner_other, needs_wait, busy_hit, fwd_done, done_now;
    logic             accept, go, start_wait, quick;

    dirc_store #(.NPROC(NPROC), .NBLK(NBLK)) u_store (
        .clk(clk), .rst_n(rst_n), .rd_blk(req_blk),
        .rd_pres(rd_pres), .rd_dirty(rd_dirty), .rd_owner(rd_owner),
        .we(we), .wr_blk(wr_blk), .wr_pres(wr_pres),
        .wr_dirty(wr_dirty), .wr_owner(wr_owner)
    );

    dirc_acks #(.NPROC(NPROC)) u_acks (
        .clk(clk), .rst_n(rst_n), .load(start_wait && req_write),
        .load_mask(load_mask), .ack_valid(ack_valid && state_q == ST_INV_WAIT),
        .ack_id(ack_id), .last(inv_last)
    );

    // request classification
    assign req_bit     = NPROC'(1) << req_id;
    assign others      = rd_pres & ~req_bit;
    assign owner_other = rd_dirty && (rd_owner != req_id);
    assign needs_wait  = req_write ? (rd_dirty ? owner_other : |others) : owner_other;
    assign load_mask   = rd_dirty ? (NPROC'(1) << rd_owner) : others;
    assign busy_hit    = (state_q != ST_IDLE) && (pend_blk_q == req_blk);
    assign fwd_done    = (state_q == ST_FWD_WAIT) && ack_valid && (ack_id == pend_owner_q);
    assign done_now    = ((state_q == ST_INV_WAIT) && inv_last) || fwd_done;

    assign req_ready   = !done_now && ((state_q == ST_IDLE) || busy_hit || !needs_wait);
    assign accept      = req_valid && req_ready;
    assign req_nack    = accept && busy_hit;
    assign go          = accept && !busy_hit;
    assign start_wait  = go && needs_wait;
    assign quick       = go && !needs_wait;

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:     if (start_wait) state_d = req_write ? ST_INV_WAIT : ST_FWD_WAIT;
            ST_INV_WAIT: if (done_now)   state_d = ST_IDLE;
            ST_FWD_WAIT: if (done_now)   state_d = ST_IDLE;
            default:                     state_d = ST_IDLE;
        endcase
    end

    // record update
    always_comb begin
        we       = 1'b0;
        wr_blk   = req_blk;
        wr_pres  = rd_pres;
        wr_dirty = rd_dirty;
        wr_owner = rd_owner;
        if (done_now) begin
            we     = 1'b1;
            wr_blk = pend_blk_q;
            if (state_q == ST_INV_WAIT) begin
                wr_pres  = '0;
                wr_dirty = 1'b1;
                wr_owner = pend_req_q;
            end else begin
                wr_pres  = (NPROC'(1) << pend_owner_q) | (NPROC'(1) << pend_req_q);
                wr_dirty = 1'b0;
                wr_owner = '0;
            end
        end else if (quick && !rd_dirty) begin
            we = 1'b1;
            if (req_write) begin
                wr_pres  = '0;
                wr_dirty = 1'b1;
                wr_owner = req_id;
            end else begin
                wr_pres  = rd_pres | req_bit;
            end
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q      <= ST_IDLE;
            pend_blk_q   <= '0;
            pend_req_q   <= '0;
            pend_owner_q <= '0;
        end else begin
            state_q <= state_d;
            if (start_wait) begin
                pend_blk_q   <= req_blk;
                pend_req_q   <= req_id;
                pend_owner_q <= rd_owner;
            end
        end
    end

    // registered messages and grants
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            inv_valid <= 1'b0; inv_mask  <= '0; inv_blk <= '0;
            fwd_valid <= 1'b0; fwd_owner <= '0; fwd_req <= '0; fwd_blk <= '0;
            rsp_valid <= 1'b0; rsp_write <= 1'b0; rsp_id <= '0; rsp_blk <= '0;
        end else begin
            inv_valid <= start_wait && req_write;
            inv_mask  <= load_mask;
            inv_blk   <= req_blk;
            fwd_valid <= start_wait && !req_write;
            fwd_owner <= rd_owner;
            fwd_req   <= req_id;
            fwd_blk   <= req_blk;
            rsp_valid <= done_now || quick;
            rsp_write <= done_now ? (state_q == ST_INV_WAIT) : req_write;
            rsp_id    <= done_now ? pend_req_q : req_id;
            rsp_blk   <= done_now ? pend_blk_q : req_blk;
        end
    end

    for (genvar b = 0; b < NBLK; b++) begin : g_busy
        assign blk_busy[b] = (state_q != ST_IDLE) && (pend_blk_q == BW'(b));
    end
endmodule

// File: rtl/dirc_checker.sv
module dirc_checker #(
    parameter int unsigned NPROC = 8,
    parameter int unsigned NBLK  = 16,
    localparam int unsigned IDW  = $clog2(NPROC),
    localparam int unsigned BW   = $clog2(NBLK)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic             req_ready,
    input logic [BW-1:0]    req_blk,
    input logic             req_nack,
    input logic             ack_valid,
    input logic             inv_valid,
    input logic [NPROC-1:0] inv_mask,
    input logic [BW-1:0]    inv_blk,
    input logic             fwd_valid,
    input logic [BW-1:0]    fwd_blk,
    input logic             rsp_valid,
    input logic [BW-1:0]    rsp_blk,
    input logic [NBLK-1:0]  blk_busy
);
    AST_ONE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(blk_busy)); // R10
    AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (|blk_busy && !ack_valid) |=> $stable(blk_busy)); // R10
    AST_NACK_ON_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        req_nack |-> (req_valid && req_ready && blk_busy[req_blk])); // R5
    AST_INV_MARKS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        inv_valid |-> (blk_busy[inv_blk] && inv_mask != '0)); // R3
    AST_FWD_MARKS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        fwd_valid |-> blk_busy[fwd_blk]); // R6
    AST_GRANT_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> !blk_busy[rsp_blk]); // R3
endmodule

bind home_directory dirc_checker #(.NPROC(NPROC), .NBLK(NBLK)) u_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_blk(req_blk), .req_nack(req_nack), .ack_valid(ack_valid),
    .inv_valid(inv_valid), .inv_mask(inv_mask), .inv_blk(inv_blk),
    .fwd_valid(fwd_valid), .fwd_blk(fwd_blk), .rsp_valid(rsp_valid),
    .rsp_blk(rsp_blk), .blk_busy(blk_busy)
);

// File: tb/sim_home_directory.sv
`timescale 1ns/1ps
module sim_home_directory;
    logic clk = 1'b0, rst_n = 1'b0;
    logic req_valid = 1'b0, req_write = 1'b0, ack_valid = 1'b0;
    logic [2:0] req_id = '0, ack_id = '0;
    logic [3:0] req_blk = '0;
    logic req_ready, req_nack, inv_valid, fwd_valid, rsp_valid, rsp_write;
    logic [7:0] inv_mask;
    logic [3:0] inv_blk, fwd_blk, rsp_blk;
    logic [2:0] fwd_owner, fwd_req, rsp_id;
    logic [15:0] blk_busy;

    int checks = 0, fails = 0;
    logic [7:0] exp_q[$];
    string      tag_q[$];
    logic rdy, nk;

    always #5 clk = ~clk;

    home_directory u0 (.*);

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic expect_rsp(input bit wr, input int id, input int blk, input string tag);
        exp_q.push_back({wr, 3'(id), 4'(blk)});
        tag_q.push_back(tag);
    endtask

    // monitor: pops expected grants as the design produces them
    always @(negedge clk) begin
        if (rst_n && rsp_valid) begin
            if (exp_q.size() == 0) chk(0, "R5 unexpected grant", {rsp_write, rsp_id, rsp_blk}, 0);
            else begin
                logic [7:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                chk({rsp_write, rsp_id, rsp_blk} == e, t, {rsp_write, rsp_id, rsp_blk}, e);
            end
        end
    end

    task automatic send(input bit wr, input int id, input int blk);
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_id = 3'(id); req_blk = 4'(blk);
        #1; rdy = req_ready; nk = req_nack;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic ack(input int id);
        @(negedge clk);
        ack_valid = 1'b1; ack_id = 3'(id);
        @(negedge clk);
        ack_valid = 1'b0;
    endtask

    initial begin
        #2_000_000;
        chk(0, "watchdog expired", 0, 1);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(blk_busy == 0 && req_ready && !inv_valid && !fwd_valid && !rsp_valid, "R1 reset state",
            {blk_busy, 4'(req_ready)}, 1);

        // clean reads from an empty record
        expect_rsp(0, 0, 3, "R1 R2 read P0 b3"); send(0, 0, 3);
        chk(!fwd_valid && !inv_valid, "R1 no message on first read", fwd_valid, 0);
        expect_rsp(0, 2, 3, "R2 read P2 b3"); send(0, 2, 3);
        expect_rsp(0, 3, 3, "R2 read P3 b3"); send(0, 3, 3);

        // write with sharers: writer bit excluded
        send(1, 0, 3);
        chk(inv_valid && inv_mask == 8'h0C && inv_blk == 3, "R3 inv mask", inv_mask, 8'h0C);
        chk(blk_busy == 16'h0008, "R3 busy", blk_busy, 16'h0008);
        send(0, 5, 3);
        chk(rdy && nk, "R5 nack same cycle", {rdy, nk}, 3);

        // other blocks while b3 waits
        expect_rsp(0, 1, 7, "R9 read other block"); send(0, 1, 7);
        expect_rsp(1, 4, 8, "R4 R9 write unshared"); send(1, 4, 8);
        chk(!inv_valid, "R4 no inv", inv_valid, 0);
        send(0, 6, 8);
        chk(!rdy && !nk, "R9 held off", rdy, 0);

        ack(2);
        chk(blk_busy == 16'h0008, "R3 still busy", blk_busy, 16'h0008);
        ack(2); ack(7);
        chk(blk_busy == 16'h0008, "R8 stray acks ignored", blk_busy, 16'h0008);
        expect_rsp(1, 0, 3, "R3 write grant"); ack(3);
        chk(blk_busy == 0, "R3 released", blk_busy, 0);

        // owner access
        expect_rsp(1, 0, 3, "R11 owner write"); send(1, 0, 3);
        chk(!inv_valid, "R11 no inv", inv_valid, 0);
        expect_rsp(0, 0, 3, "R11 owner read"); send(0, 0, 3);
        chk(!fwd_valid, "R11 no fwd", fwd_valid, 0);

        // forwarded read
        send(0, 1, 3);
        chk(fwd_valid && fwd_owner == 0 && fwd_req == 1 && fwd_blk == 3, "R6 forward",
            {fwd_valid, fwd_owner, fwd_req}, {1'b1, 3'd0, 3'd1});
        ack(5);
        chk(blk_busy == 16'h0008, "R8 non-owner ack ignored", blk_busy, 16'h0008);
        expect_rsp(0, 1, 3, "R6 forwarded grant"); ack(0);
        send(1, 6, 3);
        chk(inv_valid && inv_mask == 8'h03, "R6 both holders", inv_mask, 8'h03);
        ack(0);
        expect_rsp(1, 6, 3, "R6 write after forward"); ack(1);

        // ownership moves
        send(1, 2, 3);
        chk(inv_valid && inv_mask == 8'h40, "R7 inv old owner", inv_mask, 8'h40);
        expect_rsp(1, 2, 3, "R7 new owner grant"); ack(6);
        send(0, 4, 3);
        chk(fwd_valid && fwd_owner == 2, "R7 forward to new owner", fwd_owner, 2);
        expect_rsp(0, 4, 3, "R7 forward grant"); ack(2);

        send(0, 6, 8);
        chk(fwd_valid && fwd_owner == 4 && fwd_blk == 8, "R6 forward b8", fwd_owner, 4);
        expect_rsp(0, 6, 8, "R6 b8 grant"); ack(4);

        repeat (3) @(negedge clk);
        chk(exp_q.size() == 0, "R3 all grants seen", exp_q.size(), 0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule